// File: doc/BRIEF.md
# Transition-Coded Bus Encoder

This block drives an 8-bit on-chip bus over nine physical wires and aims to cut the number of wires that switch. It does not send the data word itself. Instead it codes the step from one word to the next. Every accepted word forms an arc with the word accepted before it. The arc is looked up in a small table of ranked arcs. On a hit, the stored mask is XORed into the eight data wires, so each 1 in the mask flips exactly one wire. Low-weight masks, down to an all-zero mask for the most common arc, therefore make the frequent steps cheap.

Arcs that are not in the table are sent as the raw word. The ninth wire flips to tell the receiver that the lanes now carry plain data. Table entries are loaded through a synchronous write port. The paired decoder must be given the same contents. Within one previous word, masks must be unique, and only the top-ranked arc may use the zero mask, so that the decoder can always recover the data. Gathering arc statistics and ranking the arcs are done elsewhere.

Top module: `tcx_encoder`

## Requirements
- R1: While reset is high, the bus output is driven to 9'h000 and the stored previous word becomes 8'h00, so the first accepted word forms an arc from 8'h00.
- R2: When an accepted word and the stored previous word match a valid entry (entry prev equals stored word, entry cur equals new word), bus bits [7:0] become their old value XOR the entry's mask and bus bit 8 keeps its value, one edge after the word is presented.
- R3: When an accepted word matches no valid entry, bus bits [7:0] take the raw word and bus bit 8 inverts.
- R4: A match needs both halves of the arc; an entry whose cur field equals the new word but whose prev field differs from the stored word is a miss.
- R5: When several valid entries match the same arc, the entry with the lowest index supplies the mask.
- R6: An entry written with its valid bit at 0 never produces a hit.
- R7: While in_valid is low the bus holds its value and the stored previous word is not changed, whatever in_data carries.
- R8: A write on the table port takes effect at the clock edge, and lookups in later cycles use the new contents; rewriting an index replaces or disables the old entry.
- R9: A hit on an entry with mask 8'h00 leaves all nine bus wires unchanged.
- R10: The stored previous word takes every accepted word, whether that word was a hit or a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A data word is presented this cycle |
| in_data | input | 8 | Data word to transmit |
| wr_en | input | 1 | Write one table entry at this edge |
| wr_idx | input | IDX_W | Index of the entry to write |
| wr_prev | input | 8 | Previous-word half of the arc |
| wr_cur | input | 8 | Current-word half of the arc |
| wr_code | input | 8 | XOR mask assigned to the arc |
| wr_valid | input | 1 | Valid bit stored with the entry |
| bus_out | output | 9 | Wires: [7:0] data lanes, [8] uncoded-transfer flag |

## Verification
The bench loads arcs in which one has the same cur word as another but a different prev word. A block keyed on the current word alone would report a hit there and miss the flag toggle. It also places two matching entries at different indices and expects the lower one's mask, which catches a reversed priority. It sends a word whose arc sits in an entry written invalid, and expects the raw word with the flag flipped. It holds in_valid low while in_data changes, then sends a word whose arc only hits if the previous word was left alone. This exposes a block that lets idle cycles load the previous-word register. A zero-mask hit must leave the bus bit-exact, and a long mixed stream checks every edge against a model of the rules.

// File: rtl/tcx_pkg.sv
package tcx_pkg;

    localparam int WORD_W = 8;
    localparam int BUS_W  = WORD_W + 1;

    typedef logic [WORD_W-1:0] word_t;

    // One ranked arc of the transition table.
    typedef struct packed {
        logic  valid;
        word_t prev;
        word_t cur;
        word_t code;
    } arc_t;

    // Result of the table search for the current arc.
    typedef struct packed {
        logic  hit;
        word_t code;
    } lookup_t;

    // Physical wires: flag wire above the data lanes.
    typedef struct packed {
        logic  flag;
        word_t lanes;
    } bus_t;

    localparam arc_t  ARC_EMPTY = '{valid: 1'b0, prev: '0, cur: '0, code: '0};
    localparam bus_t  BUS_IDLE  = '{flag: 1'b0, lanes: '0};

    // Next wire state for one accepted word.
    function automatic bus_t next_bus(bus_t now, lookup_t lk, word_t data);
        bus_t nxt;
        if (lk.hit) begin
            nxt.flag  = now.flag;
            nxt.lanes = now.lanes ^ lk.code;
        end else begin
            nxt.flag  = ~now.flag;
            nxt.lanes = data;
        end
        return nxt;
    endfunction

    // True when an entry describes the arc prev -> cur.
    function automatic logic arc_matches(arc_t a, word_t prev, word_t cur);
        return a.valid && (a.prev == prev) && (a.cur == cur);
    endfunction

endpackage

// File: rtl/tcx_arc_table.sv
module tcx_arc_table
    import tcx_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  arc_t                wr_arc,
    output arc_t [ENTRIES-1:0]  arcs_o
);

    arc_t [ENTRIES-1:0] arcs_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                arcs_q[e] <= ARC_EMPTY;
            end else if (sel) begin
                arcs_q[e] <= wr_arc;
            end
        end
    end

    assign arcs_o = arcs_q;

endmodule

// File: rtl/tcx_arc_match.sv
module tcx_arc_match
    import tcx_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  arc_t [ENTRIES-1:0]  arcs,
    input  word_t               prev_word,
    input  word_t               cur_word,
    output logic [ENTRIES-1:0]  grant,
    output lookup_t             result
);

    logic [ENTRIES-1:0] hits;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hits[e] = arc_matches(arcs[e], prev_word, cur_word);
    end

    // Isolate the lowest set bit: lowest index wins.
    assign grant = hits & (~hits + ENTRIES'(1));

    always_comb begin
        word_t code_acc;
        code_acc = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            code_acc |= arcs[e].code & {WORD_W{grant[e]}};
        end
        result.hit  = |hits;
        result.code = code_acc;
    end

endmodule

// File: rtl/tcx_bus_drive.sv
module tcx_bus_drive
    import tcx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  word_t   in_data,
    input  lookup_t lk,
    output word_t   prev_o,
    output bus_t    bus_o
);

    word_t prev_q;
    bus_t  bus_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            bus_q  <= BUS_IDLE;
        end else if (in_valid) begin
            prev_q <= in_data;
            bus_q  <= next_bus(bus_q, lk, in_data);
        end
    end

    assign prev_o = prev_q;
    assign bus_o  = bus_q;

endmodule

// File: rtl/tcx_encoder.sv
module tcx_encoder
    import tcx_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    in_data,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [WORD_W-1:0]    wr_prev,
    input  logic [WORD_W-1:0]    wr_cur,
    input  logic [WORD_W-1:0]    wr_code,
    input  logic                 wr_valid,
    output logic [BUS_W-1:0]     bus_out
);

    arc_t [ENTRIES-1:0] arcs;
    arc_t               wr_arc;
    logic [ENTRIES-1:0] grant;
    lookup_t            lk;
    word_t              prev_word;
    bus_t               bus_q;

    assign wr_arc = '{valid: wr_valid, prev: wr_prev, cur: wr_cur, code: wr_code};

    tcx_arc_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_arc (wr_arc),
        .arcs_o (arcs)
    );

    tcx_arc_match #(.ENTRIES(ENTRIES)) u_match (
        .arcs      (arcs),
        .prev_word (prev_word),
        .cur_word  (in_data),
        .grant     (grant),
        .result    (lk)
    );

    tcx_bus_drive u_drive (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .lk       (lk),
        .prev_o   (prev_word),
        .bus_o    (bus_q)
    );

    assign bus_out = bus_q;

endmodule

// File: rtl/tcx_encoder_chk.sv
module tcx_encoder_chk
    import tcx_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    input  logic [BUS_W-1:0]    bus_out,
    input  logic                lk_hit,
    input  logic [WORD_W-1:0]   lk_code,
    input  logic [ENTRIES-1:0]  grant
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            reset_bus_zero_chk: assert (bus_out == '0);
        end
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(bus_out));

    // R3
    flag_toggle_raw_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (bus_out[WORD_W] == $past(bus_out[WORD_W])) ||
                     (bus_out[WORD_W-1:0] == $past(in_data)));

    // R2
    hit_weight_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lk_hit) |=>
            ($countones(bus_out ^ $past(bus_out)) == $countones($past(lk_code))));

    // R2
    hit_flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lk_hit) |=> (bus_out[WORD_W] == $past(bus_out[WORD_W])));

    // R5
    single_winner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R3
    miss_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (grant == '0));

endmodule

bind tcx_encoder tcx_encoder_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .bus_out  (bus_out),
    .lk_hit   (lk.hit),
    .lk_code  (lk.code),
    .grant    (grant)
);

// File: tb/sim_tcx_encoder.sv
`timescale 1ns/1ps
module sim_tcx_encoder;

    localparam int ENTRIES = 16;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam time CLK_P  = 20ns;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [7:0]       wr_prev = '0, wr_cur = '0, wr_code = '0;
    logic             wr_valid = 1'b0;
    logic [8:0]       bus_out;

    always #(CLK_P/2) clk = ~clk;

    tcx_encoder #(.ENTRIES(ENTRIES)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_prev(wr_prev), .wr_cur(wr_cur),
        .wr_code(wr_code), .wr_valid(wr_valid), .bus_out(bus_out)
    );

    // Bench model of the table and wires.
    logic       m_v [ENTRIES];
    logic [7:0] m_p [ENTRIES];
    logic [7:0] m_c [ENTRIES];
    logic [7:0] m_k [ENTRIES];
    logic [8:0] exp_bus;
    logic [7:0] exp_prev;

    logic [8:0] q_bus [$];
    string      q_tag [$];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic fire = 1'b0;

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: bus_out=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < ENTRIES; i++) begin
            m_v[i] = 1'b0; m_p[i] = '0; m_c[i] = '0; m_k[i] = '0;
        end
        exp_bus  = '0;
        exp_prev = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic write_arc(int idx, logic [7:0] p, logic [7:0] c,
                             logic [7:0] k, logic v);
        wr_en = 1'b1; wr_idx = IDX_W'(idx);
        wr_prev = p; wr_cur = c; wr_code = k; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_v[idx] = v; m_p[idx] = p; m_c[idx] = c; m_k[idx] = k;
    endtask

    // Driver: presents one word and queues the expected wire state.
    task automatic send(logic [7:0] w, string tag);
        bit hit = 1'b0;
        logic [7:0] code = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!hit && m_v[i] && m_p[i] == exp_prev && m_c[i] == w) begin
                hit = 1'b1; code = m_k[i];
            end
        end
        if (hit) exp_bus = {exp_bus[8], exp_bus[7:0] ^ code};
        else     exp_bus = {~exp_bus[8], w};
        exp_prev = w;
        q_bus.push_back(exp_bus);
        q_tag.push_back(tag);
        in_valid = 1'b1; in_data = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compares after every accepted word.
    always @(posedge clk) fire <= in_valid && !rst;

    initial begin
        forever begin
            @(negedge clk);
            if (fire) begin
                if (q_bus.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL scoreboard: output with empty queue, bus_out=%h expected none", bus_out);
                end else begin
                    check(q_tag.pop_front(), bus_out, q_bus.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    logic [15:0] lfsr;
    logic [7:0]  alpha [4];

    initial begin
        model_reset();
        do_reset();
        check("R1 reset bus value", bus_out, 9'h000);

        write_arc(3, 8'h00, 8'h5A, 8'h03, 1'b1);
        send(8'h5A, "R1 arc from reset prev 00, R2 hit mask 03");   // 003
        send(8'h5A, "R3 miss sends raw word and flips flag");       // 15A
        write_arc(0, 8'h5A, 8'h11, 8'h00, 1'b1);
        send(8'h11, "R9 zero mask, R10 prev took missed word");     // 15A
        write_arc(5, 8'h11, 8'h22, 8'h81, 1'b1);
        write_arc(2, 8'h11, 8'h22, 8'h10, 1'b1);
        send(8'h22, "R5 lowest index mask 10");                     // 14A
        write_arc(7, 8'h99, 8'h33, 8'h0F, 1'b1);
        send(8'h33, "R4 cur matches but prev differs");             // 033
        write_arc(8, 8'h33, 8'h44, 8'h01, 1'b0);
        send(8'h44, "R6 invalid entry ignored");                    // 144

        write_arc(9, 8'h44, 8'h66, 8'h02, 1'b1);
        in_data = 8'h55;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_data = in_data + 8'h11;
            check("R7 bus holds while idle", bus_out, exp_bus);
        end
        send(8'h66, "R7 prev unchanged by idle data");              // 146

        write_arc(1, 8'h66, 8'h11, 8'h20, 1'b1);
        send(8'h11, "R8 newly written entry hits");                 // 166
        write_arc(2, 8'h11, 8'h22, 8'h10, 1'b0);
        send(8'h22, "R8 disabled entry yields to next index");      // 1E7

        // Mixed stream on a fresh table.
        do_reset();
        check("R1 reset bus after second reset", bus_out, 9'h000);
        alpha[0] = 8'h10; alpha[1] = 8'h20; alpha[2] = 8'h30; alpha[3] = 8'h40;
        write_arc(0, 8'h10, 8'h20, 8'h00, 1'b1);
        write_arc(1, 8'h20, 8'h30, 8'h01, 1'b1);
        write_arc(2, 8'h30, 8'h40, 8'h02, 1'b1);
        write_arc(3, 8'h40, 8'h10, 8'h04, 1'b1);
        write_arc(4, 8'h20, 8'h10, 8'h08, 1'b1);
        write_arc(5, 8'h10, 8'h10, 8'h03, 1'b1);
        write_arc(6, 8'h10, 8'h20, 8'h80, 1'b1);
        lfsr = 16'hACE1;
        for (int n = 0; n < 60; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[5]) begin
                @(negedge clk);
                check("R7 idle in stream", bus_out, exp_bus);
            end
            send(alpha[lfsr[1:0]], "R2 R3 R5 R10 stream");
        end
        @(negedge clk);
        @(negedge clk);
        if (q_bus.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", q_bus.size());
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule